// File: doc/BRIEF.md
# Lockstep PWM Shadow-Value Transfer Controller

This block decides when fresh period, duty-cycle and dead-time values leave their shadow registers and become the active values of a group of PWM channels that run in lockstep. Software writes the shadow values through a small register-write port that carries a function code, a channel index and data. A per-channel select mask picks which channels form the synchronous group. Every transfer to the active registers happens at the edge where the counter's period-start strobe is sampled. All selected channels take their new values at that same edge. Unselected channels keep their active values.

A two-bit method field picks how transfers are triggered. In the manual method, a self-clearing arm bit gates every transfer. In the automatic method, duty values move when an update-period counter of period starts reaches a programmed limit. The streaming method works the same way, except that duty values arrive on a ready/valid stream that takes the place of a DMA engine. In all three methods, period and dead-time values still need the arm bit. The waveform generator and dead-time insertion sit outside this block. They consume the active-value outputs.

Top module: `pwm_sync_update`

## Requirements
- R1: A shadow write never changes an active output directly. A transfer copies the shadow contents held before the strobe edge, and a shadow write made in the same cycle as the strobe is kept for a later transfer.
- R2: A transfer updates all channels whose mask bit is 1 at the same edge. Channels whose mask bit is 0 keep their active period, duty and dead-time values. The mask is written with function code 1, bit i of the data selecting channel i.
- R3: Writing function code 3 with data bit 0 equal to 1 sets the arm bit, which is read on `unlock_o`. The bit stays 1 until a period-start strobe performs the transfer and reads 0 from the next cycle. Writing code 3 with bit 0 equal to 0 has no effect.
- R4: In method 0 (manual), a period-start strobe with the arm bit at 0 leaves every active value unchanged, even when the shadows hold new values.
- R5: In method 1 (automatic) and method 2 (streaming), duty values transfer on the strobe at which the update-period counter has reached the limit, regardless of the arm bit. In these methods, period and dead-time values transfer only on a strobe with the arm bit at 1.
- R6: The update-period counter counts period-start strobes. On the strobe where it equals or exceeds the limit (written with function code 2), it fires and returns to 0, so a limit L fires on every (L+1)-th strobe and a limit of 0 fires on every strobe.
- R7: In method 2, `s_ready` is 1 while fewer words than selected channels have been accepted since the last duty transfer. The k-th accepted word (k from 0) goes to the duty shadow of the k-th selected channel in ascending index order. A duty transfer restarts the count. Outside method 2, `s_ready` is 0.
- R8: In method 2, CPU duty writes (function code 5) are ignored. Period (code 4) and dead-time (code 6) shadows stay CPU-written in every method, the dead-time taking the low DTW data bits.
- R9: Function code 0 writes the method from data bits 1:0 (0 manual, 1 automatic, 2 streaming). Writing the value 3 is ignored and the previous method stays in force.
- R10: A synchronous active-high reset clears all shadow and active values, the mask, the limit, the arm bit, the counter and the stream fill count, and sets method 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_code | input | 3 | Function code: 0 method, 1 mask, 2 limit, 3 arm, 4 period, 5 duty, 6 dead-time |
| wr_ch | input | $clog2(NCH) | Channel index for codes 4 to 6 |
| wr_data | input | PW | Write data |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| s_valid | input | 1 | Stream duty word valid |
| s_data | input | PW | Stream duty word |
| s_ready | output | 1 | Stream ready |
| unlock_o | output | 1 | Arm bit readback |
| act_period | output | NCH*PW | Active periods, channel i at bits i*PW upward |
| act_duty | output | NCH*PW | Active duty values, same packing |
| act_dt | output | NCH*DTW | Active dead-times, channel i at bits i*DTW upward |

## Verification
All results are due one cycle after their cause. Active values change at the rising edge where the strobe is sampled. The arm bit reads back its new value one edge after the write or the transfer. `s_ready` falls at the edge that accepts the last word the selected channels need. The bench drives every input just after a falling edge and runs its behavioural model at the rising edge. It compares all outputs against the model at the following falling edge, so every comparison falls exactly one register stage after its stimulus. Directed checks at fixed points pin the expected values for the arm, counter-limit, stream-order and ignored-write cases.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  typedef enum logic [1:0] {
    UPD_MANUAL = 2'd0,
    UPD_AUTO   = 2'd1,
    UPD_STREAM = 2'd2
  } upd_mode_e;

  localparam logic [2:0] FC_MODE   = 3'd0;
  localparam logic [2:0] FC_MASK   = 3'd1;
  localparam logic [2:0] FC_LIMIT  = 3'd2;
  localparam logic [2:0] FC_ARM    = 3'd3;
  localparam logic [2:0] FC_PERIOD = 3'd4;
  localparam logic [2:0] FC_DUTY   = 3'd5;
  localparam logic [2:0] FC_DEAD   = 3'd6;

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int UPRW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [UPRW-1:0] limit,
  output logic            fire
);

  logic [UPRW-1:0] cnt_q;

  assign fire = tick && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= fire ? '0 : cnt_q + 1'b1;
  end

  // R6
  wrap_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_stream_fill.sv
module pwm_stream_fill #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [NCH-1:0] mask,
  input  logic           s_valid,
  input  logic           clear,
  output logic           s_ready,
  output logic           accept,
  output logic [NCH-1:0] tgt
);

  localparam int FW = $clog2(NCH + 1);

  logic [FW-1:0] fill_q;
  logic [FW-1:0] sel_cnt;
  logic [FW-1:0] rank;

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NCH; i++) sel_cnt = sel_cnt + FW'(mask[i]);
  end

  always_comb begin
    rank = '0;
    tgt  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (mask[i]) begin
        if (rank == fill_q) tgt[i] = 1'b1;
        rank = rank + 1'b1;
      end
    end
  end

  assign s_ready = en && (fill_q < sel_cnt);
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst)         fill_q <= '0;
    else if (clear)  fill_q <= accept ? FW'(1) : '0;
    else if (accept) fill_q <= fill_q + 1'b1;
  end

  // R7
  tgt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt));

  // R7
  accept_has_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> ($countones(tgt) == 1));

  // R7
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !clear) |=> (fill_q == $past(fill_q) + 1'b1));

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs #(
  parameter int PW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic           wr_per,
  input  logic           wr_duty,
  input  logic           wr_dead,
  input  logic [PW-1:0]  wr_data,
  input  logic           str_we,
  input  logic [PW-1:0]  str_data,
  input  logic           xfer_pd,
  input  logic           xfer_duty,
  output logic [PW-1:0]  act_per,
  output logic [PW-1:0]  act_duty,
  output logic [DTW-1:0] act_dead
);

  logic [PW-1:0]  sh_per, sh_duty;
  logic [DTW-1:0] sh_dead;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_per  <= '0;
      sh_duty <= '0;
      sh_dead <= '0;
    end else begin
      if (wr_per)       sh_per  <= wr_data;
      if (wr_dead)      sh_dead <= wr_data[DTW-1:0];
      if (str_we)       sh_duty <= str_data;
      else if (wr_duty) sh_duty <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_per  <= '0;
      act_duty <= '0;
      act_dead <= '0;
    end else if (sel) begin
      if (xfer_pd) begin
        act_per  <= sh_per;
        act_dead <= sh_dead;
      end
      if (xfer_duty) act_duty <= sh_duty;
    end
  end

  // R2
  unsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ($stable(act_per) && $stable(act_duty) && $stable(act_dead)));

endmodule

// File: rtl/pwm_sync_update.sv
module pwm_sync_update
  import pwm_sync_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int PW   = 16,
  parameter int DTW  = 8,
  parameter int UPRW = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [2:0]               wr_code,
  input  logic [$clog2(NCH)-1:0]   wr_ch,
  input  logic [PW-1:0]            wr_data,
  input  logic                     period_start,
  input  logic                     s_valid,
  input  logic [PW-1:0]            s_data,
  output logic                     s_ready,
  output logic                     unlock_o,
  output logic [NCH*PW-1:0]        act_period,
  output logic [NCH*PW-1:0]        act_duty,
  output logic [NCH*DTW-1:0]       act_dt
);

  upd_mode_e       mode_q;
  logic [NCH-1:0]  mask_q;
  logic [UPRW-1:0] limit_q;
  logic            unlock_q;
  logic            set_arm, xfer_pd, xfer_duty, fire, accept;
  logic [NCH-1:0]  tgt;

  assign set_arm   = wr_en && (wr_code == FC_ARM) && wr_data[0];
  assign xfer_pd   = period_start && unlock_q;
  assign xfer_duty = (mode_q == UPD_MANUAL) ? xfer_pd : fire;
  assign unlock_o  = unlock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= UPD_MANUAL;
      mask_q  <= '0;
      limit_q <= '0;
    end else if (wr_en) begin
      if (wr_code == FC_MODE && wr_data[1:0] != 2'd3)
        mode_q <= upd_mode_e'(wr_data[1:0]);
      if (wr_code == FC_MASK)  mask_q  <= wr_data[NCH-1:0];
      if (wr_code == FC_LIMIT) limit_q <= wr_data[UPRW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          unlock_q <= 1'b0;
    else if (set_arm) unlock_q <= 1'b1;
    else if (xfer_pd) unlock_q <= 1'b0;
  end

  pwm_period_counter #(.UPRW(UPRW)) u_cnt (
    .clk(clk), .rst(rst), .tick(period_start), .limit(limit_q), .fire(fire)
  );

  pwm_stream_fill #(.NCH(NCH)) u_fill (
    .clk(clk), .rst(rst), .en(mode_q == UPD_STREAM), .mask(mask_q),
    .s_valid(s_valid), .clear(xfer_duty), .s_ready(s_ready),
    .accept(accept), .tgt(tgt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == i[$clog2(NCH)-1:0]);
    pwm_chan_regs #(.PW(PW), .DTW(DTW)) u_ch (
      .clk(clk), .rst(rst), .sel(mask_q[i]),
      .wr_per (hit && wr_code == FC_PERIOD),
      .wr_duty(hit && wr_code == FC_DUTY && mode_q != UPD_STREAM),
      .wr_dead(hit && wr_code == FC_DEAD),
      .wr_data(wr_data),
      .str_we(accept && tgt[i]), .str_data(s_data),
      .xfer_pd(xfer_pd), .xfer_duty(xfer_duty),
      .act_per (act_period[i*PW +: PW]),
      .act_duty(act_duty[i*PW +: PW]),
      .act_dead(act_dt[i*DTW +: DTW])
    );
  end

  // R3
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (period_start && unlock_q && !set_arm) |=> !unlock_o);

  // R3
  arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (unlock_q && !period_start) |=> unlock_o);

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == UPD_MANUAL && !unlock_q)
      |=> ($stable(act_period) && $stable(act_duty) && $stable(act_dt)));

  // R1
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !period_start |=> ($stable(act_period) && $stable(act_duty) && $stable(act_dt)));

  // R5
  pd_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    !unlock_q |=> ($stable(act_period) && $stable(act_dt)));

  // R7
  ready_mode_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (mode_q == UPD_STREAM));

endmodule

// File: tb/pwm_sync_update_bench.sv
`timescale 1ns/1ps
module pwm_sync_update_bench;
  localparam int NCH = 4, PW = 16, DTW = 8, UPRW = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic wr_en = 0, period_start = 0, s_valid = 0;
  logic [2:0] wr_code = '0;
  logic [1:0] wr_ch = '0;
  logic [PW-1:0] wr_data = '0, s_data = '0;
  logic s_ready, unlock_o;
  logic [NCH*PW-1:0] act_period, act_duty;
  logic [NCH*DTW-1:0] act_dt;

  pwm_sync_update #(.NCH(NCH), .PW(PW), .DTW(DTW), .UPRW(UPRW)) u_pwm_sync_update (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .wr_ch(wr_ch),
    .wr_data(wr_data), .period_start(period_start), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .unlock_o(unlock_o),
    .act_period(act_period), .act_duty(act_duty), .act_dt(act_dt));

  int errors = 0, checks = 0;
  string req = "R10";
  bit started = 0;

  // behavioural reference model
  int m_mode, m_mask, m_lim, m_unl, m_cnt, m_fill, m_acc_total;
  int sh_per[NCH], sh_duty[NCH], sh_dt[NCH], ac_per[NCH], ac_duty[NCH], ac_dt[NCH];

  function automatic int nsel();
    int n = 0;
    for (int i = 0; i < NCH; i++) if (m_mask[i]) n++;
    return n;
  endfunction

  function automatic int m_ready();
    return (m_mode == 2 && m_fill < nsel()) ? 1 : 0;
  endfunction

  always @(posedge clk) begin : model
    int xpd, fire, xd, acc, tgt, rank, d;
    started = 1;
    if (rst) begin
      m_mode = 0; m_mask = 0; m_lim = 0; m_unl = 0; m_cnt = 0; m_fill = 0;
      for (int i = 0; i < NCH; i++) begin
        sh_per[i] = 0; sh_duty[i] = 0; sh_dt[i] = 0;
        ac_per[i] = 0; ac_duty[i] = 0; ac_dt[i] = 0;
      end
    end else begin
      d    = int'(wr_data);
      xpd  = (period_start && m_unl) ? 1 : 0;
      fire = (period_start && m_cnt >= m_lim) ? 1 : 0;
      xd   = (m_mode == 0) ? xpd : fire;
      acc  = (s_valid && m_ready() != 0) ? 1 : 0;
      tgt = -1; rank = 0;
      for (int i = 0; i < NCH; i++)
        if (m_mask[i]) begin
          if (rank == m_fill) tgt = i;
          rank++;
        end
      for (int i = 0; i < NCH; i++)
        if (m_mask[i]) begin
          if (xpd != 0) begin ac_per[i] = sh_per[i]; ac_dt[i] = sh_dt[i]; end
          if (xd != 0) ac_duty[i] = sh_duty[i];
        end
      if (xpd != 0) m_unl = 0;
      if (period_start) m_cnt = (fire != 0) ? 0 : m_cnt + 1;
      if (xd != 0) m_fill = acc;
      else if (acc != 0) m_fill++;
      if (acc != 0) begin sh_duty[tgt] = int'(s_data); m_acc_total++; end
      if (wr_en) begin
        case (wr_code)
          3'd0: if ((d & 3) != 3) m_mode = d & 3;
          3'd1: m_mask = d & ((1 << NCH) - 1);
          3'd2: m_lim = d & ((1 << UPRW) - 1);
          3'd3: if (d & 1) m_unl = 1;
          3'd4: sh_per[wr_ch] = d;
          3'd5: if (m_mode != 2) sh_duty[wr_ch] = d;
          3'd6: sh_dt[wr_ch] = d & ((1 << DTW) - 1);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin : compare
    logic [NCH*PW-1:0] ep, ed;
    logic [NCH*DTW-1:0] et;
    if (started) begin
      for (int i = 0; i < NCH; i++) begin
        ep[i*PW +: PW]   = PW'(ac_per[i]);
        ed[i*PW +: PW]   = PW'(ac_duty[i]);
        et[i*DTW +: DTW] = DTW'(ac_dt[i]);
      end
      checks++;
      if (act_period !== ep || act_duty !== ed || act_dt !== et ||
          unlock_o !== 1'(m_unl) || s_ready !== 1'(m_ready())) begin
        errors++;
        $display("FAIL %s t=%0t per=%h exp %h duty=%h exp %h dt=%h exp %h arm=%b exp %0d rdy=%b exp %0d",
                 req, $time, act_period, ep, act_duty, ed, act_dt, et,
                 unlock_o, m_unl, s_ready, m_ready());
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", r, got, exp);
    end
  endtask

  function automatic logic [31:0] duty(input int ch);
    return 32'(act_duty[ch*PW +: PW]);
  endfunction

  function automatic logic [31:0] per(input int ch);
    return 32'(act_period[ch*PW +: PW]);
  endfunction

  task automatic wr(input logic [2:0] c, input int ch, input int d);
    wr_en = 1; wr_code = c; wr_ch = 2'(ch); wr_data = PW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic strobe(input int n);
    for (int k = 0; k < n; k++) begin
      period_start = 1;
      @(negedge clk);
      period_start = 0;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired during %s", req);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset duty", 32'(act_duty), 0);
    chk("R10 reset arm/ready", {30'd0, unlock_o, s_ready}, 0);

    req = "R1";
    wr(3'd1, 0, 4'b0101);
    for (int c = 0; c < NCH; c++) begin
      wr(3'd4, c, 100 + c); wr(3'd5, c, 40 + c); wr(3'd6, c, 3 + c);
    end
    chk("R1 shadow write no effect", duty(0), 0);

    req = "R4";
    strobe(3);
    chk("R4 locked duty", duty(0), 0);
    chk("R4 locked period", per(2), 0);

    req = "R3";
    wr(3'd3, 0, 0);
    chk("R3 write 0 ignored", 32'(unlock_o), 0);
    wr(3'd3, 0, 1);
    chk("R3 armed", 32'(unlock_o), 1);
    repeat (2) @(negedge clk);
    chk("R3 held", 32'(unlock_o), 1);

    req = "R2";
    strobe(1);
    chk("R3 self-clear", 32'(unlock_o), 0);
    chk("R2 ch0 duty", duty(0), 40);
    chk("R2 ch2 duty", duty(2), 42);
    chk("R2 ch2 period", per(2), 102);
    chk("R2 ch1 unselected", duty(1), 0);

    req = "R1";
    wr(3'd3, 0, 1);
    wr(3'd5, 0, 55);
    wr_en = 1; wr_code = 3'd5; wr_ch = 0; wr_data = 16'd77; period_start = 1;
    @(negedge clk);
    wr_en = 0; period_start = 0;
    @(negedge clk);
    chk("R1 same-cycle write kept for later", duty(0), 55);

    req = "R5";
    wr(3'd0, 0, 1);
    wr(3'd2, 0, 2);
    for (int c = 0; c < NCH; c++) wr(3'd5, c, 200 + c);
    wr(3'd4, 0, 150);
    strobe(2);
    chk("R6 no fire before limit", duty(0), 55);
    strobe(1);
    chk("R5 auto duty ch0", duty(0), 200);
    chk("R5 auto duty ch2", duty(2), 202);
    chk("R5 period needs arm", per(0), 100);

    req = "R6";
    for (int c = 0; c < NCH; c++) wr(3'd5, c, 300 + c);
    strobe(2);
    chk("R6 second window early", duty(0), 200);
    strobe(1);
    chk("R6 second window fire", duty(0), 300);

    req = "R9";
    wr(3'd0, 0, 3);
    wr(3'd2, 0, 0);
    wr(3'd5, 2, 333);
    strobe(1);
    chk("R9 mode 3 ignored, auto kept; R6 limit 0", duty(2), 333);

    req = "R7";
    wr(3'd0, 0, 2);
    wr(3'd1, 0, 4'b1011);
    chk("R7 ready when empty", 32'(s_ready), 1);
    m_acc_total = 0;
    s_valid = 1;
    for (int k = 0; k < 6; k++) begin
      s_data = PW'(16'h0A00 + m_acc_total);
      @(negedge clk);
    end
    s_valid = 0;
    chk("R7 ready low when full", 32'(s_ready), 0);
    req = "R8";
    wr(3'd5, 0, 999);
    strobe(1);
    chk("R8 cpu duty ignored / R7 ch0", duty(0), 32'h0A00);
    chk("R7 ch1 word", duty(1), 32'h0A01);
    chk("R7 ch3 word", duty(3), 32'h0A02);
    chk("R7 ch2 unselected", duty(2), 333);
    chk("R7 ready after transfer", 32'(s_ready), 1);

    req = "R5";
    wr(3'd4, 1, 555);
    strobe(1);
    chk("R5 stream period needs arm", per(1), 0);
    wr(3'd3, 0, 1);
    strobe(1);
    chk("R5 stream period armed", per(1), 555);

    req = "R10";
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset period", per(1), 0);
    chk("R10 reset ready", 32'(s_ready), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule